// File: doc/BRIEF.md
# Program Counter and Branch Unit

This block owns the 12-bit fetch address of a small 4-bit processor and the three-entry return-address stack behind it. A decode stage hands it an instruction as a stream transaction. The transaction carries the opcode byte and the following byte when there is one, plus the values the branch decisions need: the selected register-pair value, a flag saying the freshly incremented register is zero, the carry, an accumulator-is-zero flag and an external test pin. On each accepted instruction the block moves the fetch address forward or to a branch target, and it pushes or pops the return stack. A separate combinational output tells the fetcher, from the opcode byte alone, whether a second byte belongs to the instruction.

A subroutine return also yields a 4-bit immediate for the accumulator. That value leaves through a one-entry valid/ready output slot. The instruction input has valid/ready handshaking. An instruction is taken on a cycle with both `ins_valid` and `ins_ready` high. `ins_ready` falls only while the return slot holds a value that the consumer is not taking in that cycle (`ret_valid` high, `ret_ready` low). `ret_valid` and `ret_data` stay fixed until `ret_ready` is seen high. A slot that drains in the same cycle as a new return is accepted reloads at once.

Top module: `pc_branch_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `fetch_addr` is 0 and `ret_valid` is 0. The return stack starts empty with every entry zero, so a return issued first after reset goes to address 0.
- R2: `ins_two_byte` is 1 when the upper nibble of `ins_op` is 1, 4, 5 or 7, or when it is 2 with bit 0 of `ins_op` clear. It is 0 for every other opcode byte.
- R3: Any accepted instruction that is not a branch moves `fetch_addr` on by its length (1 or 2) on the next cycle, wrapping modulo 4096.
- R4: A long jump (upper nibble 4) or call (upper nibble 5) loads `fetch_addr` with {`ins_op[3:0]`, `ins_arg`}.
- R5: For a conditional jump (upper nibble 1) the test is the OR of three terms: `acc_zero` when `ins_op[2]` is set, `carry` when `ins_op[1]` is set, and `test_in` low when `ins_op[0]` is set. `ins_op[3]` inverts the result. When the result is true the target is `ins_arg`; otherwise the address advances by 2.
- R6: Increment-and-skip (upper nibble 7) branches to `ins_arg` when `reg_zero` is 1, and advances by 2 otherwise.
- R7: An indirect jump (upper nibble 3, bit 0 set) branches to `pair_val`. With bit 0 clear, the same nibble is a one-byte non-branch.
- R8: An 8-bit target replaces only bits 7:0 of the address that follows the instruction itself. Bits 11:8 of the target come from that following address, so a branch at the last bytes of a page lands in the next page.
- R9: A call pushes the address after the call (its own address plus 2). A return (upper nibble 12) pops the most recent entry into `fetch_addr`.
- R10: The stack is a ring of three slots. A fourth call overwrites the oldest entry. Returns beyond the stored depth keep wrapping around the ring without any error.
- R11: An accepted return sets `ret_valid` with `ret_data` = `ins_op[3:0]` on the next cycle. Both are held until `ret_ready` is high.
- R12: `ins_ready` is 0 exactly while `ret_valid` is 1 and `ret_ready` is 0. No state changes on a cycle without an accepted instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ins_valid | input | 1 | Instruction transaction present |
| ins_ready | output | 1 | Block can take the instruction |
| ins_op | input | 8 | Opcode byte: operation nibble high, modifier nibble low |
| ins_arg | input | 8 | Second instruction byte (ignored for one-byte forms) |
| pair_val | input | 8 | Selected register-pair value for indirect jumps |
| reg_zero | input | 1 | Incremented register equals zero (increment-and-skip) |
| carry | input | 1 | Carry flag |
| acc_zero | input | 1 | Accumulator equals zero |
| test_in | input | 1 | External test pin |
| fetch_addr | output | 12 | Current program counter |
| ins_two_byte | output | 1 | Opcode byte on `ins_op` has a second byte |
| ret_valid | output | 1 | Return immediate available |
| ret_ready | input | 1 | Consumer takes the return immediate |
| ret_data | output | 4 | Immediate nibble for the accumulator |

## Verification
Two functions can land on the same edge. In the first, the return slot drains and is refilled by a new return. In the second, a call that overwrites the oldest stack entry is followed later by returns that wrap the ring. The bench leaves one return immediate pending, then raises `ret_ready` during the cycle that offers a second return. It checks that `ins_ready` stays high and that the slot then shows the new nibble with `ret_valid` still set. It also makes four nested calls and four returns, and requires the return addresses to come back in ring order, with the newest entry repeated on the fourth return.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

  localparam int OP_W   = 8;
  localparam int NIB_W  = 4;
  localparam int PAGE_W = 8;

  typedef enum logic [2:0] {
    BR_SEQ,
    BR_COND,
    BR_LONG,
    BR_CALL,
    BR_SKIPZ,
    BR_INDIR,
    BR_RET
  } br_kind_e;

  localparam logic [NIB_W-1:0] OPF_COND  = 4'h1;
  localparam logic [NIB_W-1:0] OPF_PAIR  = 4'h2;
  localparam logic [NIB_W-1:0] OPF_FETCH = 4'h3;
  localparam logic [NIB_W-1:0] OPF_LONG  = 4'h4;
  localparam logic [NIB_W-1:0] OPF_CALL  = 4'h5;
  localparam logic [NIB_W-1:0] OPF_SKIPZ = 4'h7;
  localparam logic [NIB_W-1:0] OPF_RET   = 4'hC;

endpackage

// File: rtl/pcb_decode.sv
module pcb_decode
  import pcb_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output br_kind_e        kind,
  output logic            two_byte
);

  logic [NIB_W-1:0] opf;
  logic             mod0;

  assign opf  = op[OP_W-1:NIB_W];
  assign mod0 = op[0];

  always_comb begin
    kind     = BR_SEQ;
    two_byte = 1'b0;
    case (opf)
      OPF_COND: begin
        kind     = BR_COND;
        two_byte = 1'b1;
      end
      OPF_PAIR: begin
        two_byte = ~mod0;
      end
      OPF_FETCH: begin
        if (mod0) kind = BR_INDIR;
      end
      OPF_LONG: begin
        kind     = BR_LONG;
        two_byte = 1'b1;
      end
      OPF_CALL: begin
        kind     = BR_CALL;
        two_byte = 1'b1;
      end
      OPF_SKIPZ: begin
        kind     = BR_SKIPZ;
        two_byte = 1'b1;
      end
      OPF_RET: begin
        kind = BR_RET;
      end
      default: begin
        kind     = BR_SEQ;
        two_byte = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/pcb_cond.sv
module pcb_cond
  import pcb_pkg::*;
(
  input  logic [NIB_W-1:0] cond,
  input  logic             acc_zero,
  input  logic             carry,
  input  logic             test_in,
  output logic             take
);

  logic any_hit;

  always_comb begin
    any_hit = 1'b0;
    if (cond[2] && acc_zero) any_hit = 1'b1;
    if (cond[1] && carry)    any_hit = 1'b1;
    if (cond[0] && !test_in) any_hit = 1'b1;
    take = any_hit ^ cond[3];
  end

endmodule

// File: rtl/pcb_stack.sv
module pcb_stack #(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [ADDR_W-1:0] push_addr,
  output logic [ADDR_W-1:0] top_addr
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0]  ptr_q;
  logic [PTR_W-1:0]  ptr_inc;
  logic [PTR_W-1:0]  ptr_dec;
  logic [ADDR_W-1:0] slot_q [DEPTH];

  assign ptr_inc  = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  assign ptr_dec  = (ptr_q == '0) ? LAST : ptr_q - 1'b1;
  assign top_addr = slot_q[ptr_dec];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (push) begin
      ptr_q <= ptr_inc;
    end else if (pop) begin
      ptr_q <= ptr_dec;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (push && (ptr_q == PTR_W'(g))) begin
        slot_q[g] <= push_addr;
      end
    end
  end

endmodule

// File: rtl/pc_branch_unit.sv
module pc_branch_unit
  import pcb_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int STACK_DEPTH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [7:0]        ins_op,
  input  logic [7:0]        ins_arg,
  input  logic [7:0]        pair_val,
  input  logic              reg_zero,
  input  logic              carry,
  input  logic              acc_zero,
  input  logic              test_in,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              ins_two_byte,
  output logic              ret_valid,
  input  logic              ret_ready,
  output logic [3:0]        ret_data
);

  localparam int HI_W = ADDR_W - PAGE_W;

  br_kind_e          kind;
  logic              cond_take;
  logic              accept;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_d;
  logic [ADDR_W-1:0] seq_addr;
  logic [HI_W-1:0]   page;
  logic [ADDR_W-1:0] long_tgt;
  logic [ADDR_W-1:0] stk_top;
  logic              stk_push;
  logic              stk_pop;
  logic              slot_v_q;
  logic [NIB_W-1:0]  slot_d_q;

  pcb_decode u_dec (
    .op       (ins_op),
    .kind     (kind),
    .two_byte (ins_two_byte)
  );

  pcb_cond u_cond (
    .cond     (ins_op[NIB_W-1:0]),
    .acc_zero (acc_zero),
    .carry    (carry),
    .test_in  (test_in),
    .take     (cond_take)
  );

  pcb_stack #(
    .ADDR_W (ADDR_W),
    .DEPTH  (STACK_DEPTH)
  ) u_stk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (stk_push),
    .pop       (stk_pop),
    .push_addr (seq_addr),
    .top_addr  (stk_top)
  );

  assign ins_ready = !(slot_v_q && !ret_ready);
  assign accept    = ins_valid && ins_ready;
  assign seq_addr  = pc_q + (ins_two_byte ? ADDR_W'(2) : ADDR_W'(1));
  assign page      = seq_addr[ADDR_W-1:PAGE_W];
  assign long_tgt  = ADDR_W'({ins_op[NIB_W-1:0], ins_arg});
  assign stk_push  = accept && (kind == BR_CALL);
  assign stk_pop   = accept && (kind == BR_RET);

  always_comb begin
    pc_d = seq_addr;
    unique case (kind)
      BR_COND:  if (cond_take) pc_d = {page, ins_arg};
      BR_SKIPZ: if (reg_zero)  pc_d = {page, ins_arg};
      BR_INDIR: pc_d = {page, pair_val};
      BR_LONG,
      BR_CALL:  pc_d = long_tgt;
      BR_RET:   pc_d = stk_top;
      default:  pc_d = seq_addr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (accept) begin
      pc_q <= pc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_v_q <= 1'b0;
      slot_d_q <= '0;
    end else if (stk_pop) begin
      slot_v_q <= 1'b1;
      slot_d_q <= ins_op[NIB_W-1:0];
    end else if (ret_ready) begin
      slot_v_q <= 1'b0;
    end
  end

  assign fetch_addr = pc_q;
  assign ret_valid  = slot_v_q;
  assign ret_data   = slot_d_q;

endmodule

// File: rtl/pcb_checker.sv
module pcb_checker #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ins_valid,
  input logic              ins_ready,
  input logic [7:0]        ins_op,
  input logic [7:0]        ins_arg,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              ins_two_byte,
  input logic              ret_valid,
  input logic              ret_ready,
  input logic [3:0]        ret_data
);

  logic took;
  assign took = ins_valid && ins_ready;

  p_len_long_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_op[7:4] == 4'h1 || ins_op[7:4] == 4'h4 || ins_op[7:4] == 4'h5 ||
     ins_op[7:4] == 4'h7) |-> ins_two_byte);

  p_len_short_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_op[7:4] == 4'h3 || ins_op[7:4] == 4'hC) |-> !ins_two_byte);

  p_seq_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (took && ins_op[7:4] == 4'hA) |=> fetch_addr == $past(fetch_addr) + ADDR_W'(1));

  p_long_tgt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (took && ins_op[7:4] == 4'h4) |=>
      fetch_addr == ADDR_W'({$past(ins_op[3:0]), $past(ins_arg)}));

  p_ret_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (took && ins_op[7:4] == 4'hC) |=> ret_valid && ret_data == $past(ins_op[3:0]));

  p_ret_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !ret_ready) |=> ret_valid && $stable(ret_data));

  p_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !ret_ready) |-> !ins_ready);

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !took |=> $stable(fetch_addr));

endmodule

bind pc_branch_unit pcb_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ins_valid    (ins_valid),
  .ins_ready    (ins_ready),
  .ins_op       (ins_op),
  .ins_arg      (ins_arg),
  .fetch_addr   (fetch_addr),
  .ins_two_byte (ins_two_byte),
  .ret_valid    (ret_valid),
  .ret_ready    (ret_ready),
  .ret_data     (ret_data)
);

// File: tb/tb_pc_branch_unit.sv
module tb_pc_branch_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ins_valid;
  logic        ins_ready;
  logic [7:0]  ins_op;
  logic [7:0]  ins_arg;
  logic [7:0]  pair_val;
  logic        reg_zero;
  logic        carry;
  logic        acc_zero;
  logic        test_in;
  logic [11:0] fetch_addr;
  logic        ins_two_byte;
  logic        ret_valid;
  logic        ret_ready;
  logic [3:0]  ret_data;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  pc_branch_unit dut (
    .clk (clk), .rst_n (rst_n), .ins_valid (ins_valid), .ins_ready (ins_ready),
    .ins_op (ins_op), .ins_arg (ins_arg), .pair_val (pair_val), .reg_zero (reg_zero),
    .carry (carry), .acc_zero (acc_zero), .test_in (test_in), .fetch_addr (fetch_addr),
    .ins_two_byte (ins_two_byte), .ret_valid (ret_valid), .ret_ready (ret_ready),
    .ret_data (ret_data)
  );

  // flags: {reg_zero, carry, acc_zero, test_in}
  typedef struct packed {
    logic [7:0]  op;
    logic [7:0]  arg;
    logic [7:0]  pair;
    logic [3:0]  fl;
    logic        two;
    logic [11:0] pc;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TAB [NV] = '{
    '{8'hA3, 8'h00, 8'h00, 4'b0001, 1'b0, 12'h001}, // R3 one byte
    '{8'h20, 8'h00, 8'h00, 4'b0001, 1'b1, 12'h003}, // R2 pair-immediate two bytes
    '{8'h21, 8'h00, 8'h00, 4'b0001, 1'b0, 12'h004}, // R2 bit0 set -> one byte
    '{8'h4A, 8'hFE, 8'h00, 4'b0001, 1'b1, 12'hAFE}, // R4 long jump
    '{8'h14, 8'h10, 8'h00, 4'b0011, 1'b1, 12'hB10}, // R5 R8 acc zero taken across page
    '{8'h12, 8'h55, 8'h00, 4'b0001, 1'b1, 12'hB12}, // R5 carry clear not taken
    '{8'h19, 8'h66, 8'h00, 4'b0000, 1'b1, 12'hB14}, // R5 test low inverted
    '{8'h18, 8'h33, 8'h00, 4'b0001, 1'b1, 12'hB33}, // R5 inverted empty -> taken
    '{8'h71, 8'h40, 8'h00, 4'b1001, 1'b1, 12'hB40}, // R6 zero -> branch
    '{8'h72, 8'h50, 8'h00, 4'b0001, 1'b1, 12'hB42}, // R6 nonzero -> fall through
    '{8'h33, 8'h00, 8'h77, 4'b0001, 1'b0, 12'hB77}, // R7 indirect
    '{8'h30, 8'h00, 8'h00, 4'b0001, 1'b0, 12'hB78}, // R7 bit0 clear one byte
    '{8'h51, 8'h00, 8'h00, 4'b0001, 1'b1, 12'h100}, // R9 call
    '{8'h52, 8'h00, 8'h00, 4'b0001, 1'b1, 12'h200}, // R9 nested call
    '{8'hC5, 8'h00, 8'h00, 4'b0001, 1'b0, 12'h102}, // R9 return
    '{8'hC9, 8'h00, 8'h00, 4'b0001, 1'b0, 12'hB7A}, // R9 return
    '{8'hF2, 8'h00, 8'h00, 4'b0001, 1'b0, 12'hB7B}, // R3
    '{8'h4F, 8'hFF, 8'h00, 4'b0001, 1'b1, 12'hFFF}, // R4 top address
    '{8'hA0, 8'h00, 8'h00, 4'b0001, 1'b0, 12'h000}, // R3 wrap
    '{8'h16, 8'h9A, 8'h00, 4'b0101, 1'b1, 12'h09A}, // R5 carry taken
    '{8'hE5, 8'h00, 8'h00, 4'b0001, 1'b0, 12'h09B}  // R3
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] op, input logic [7:0] arg,
                       input logic [7:0] pr, input logic [3:0] fl);
    ins_valid = 1'b1;
    ins_op    = op;
    ins_arg   = arg;
    pair_val  = pr;
    {reg_zero, carry, acc_zero, test_in} = fl;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic issue(input logic [7:0] op, input logic [7:0] arg);
    drive(op, arg, 8'h00, 4'b0001);
    tick();
    ins_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ins_valid = 1'b0;
    tick();
    tick();
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ins_valid = 1'b0; ins_op = 8'h00; ins_arg = 8'h00;
    pair_val = 8'h00; reg_zero = 1'b0; carry = 1'b0; acc_zero = 1'b0;
    test_in = 1'b1; ret_ready = 1'b1;
    @(negedge clk);
    do_reset();
    chk("R1 pc after reset", fetch_addr, 12'h000);
    chk("R1 ret_valid after reset", ret_valid, 1'b0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      drive(TAB[i].op, TAB[i].arg, TAB[i].pair, TAB[i].fl);
      #1;
      chk("R2 length decode", ins_two_byte, TAB[i].two);
      chk("R12 ready with empty slot", ins_ready, 1'b1);
      tick();
      chk("R3-R9 next address", fetch_addr, TAB[i].pc);
    end
    ins_valid = 1'b0;

    // R12: no valid -> nothing moves
    drive(8'h4F, 8'h12, 8'h00, 4'b0001);
    ins_valid = 1'b0;
    tick(); tick();
    chk("R12 idle keeps pc", fetch_addr, 12'h09B);

    // R1: return first after reset goes to zero
    do_reset();
    issue(8'h41, 8'h23);
    chk("R4 jump to 123", fetch_addr, 12'h123);
    issue(8'hC0, 8'h00);
    chk("R1 return on empty stack", fetch_addr, 12'h000);

    // R10: four calls, four returns
    do_reset();
    issue(8'h50, 8'h10);
    issue(8'h50, 8'h20);
    issue(8'h50, 8'h30);
    issue(8'h50, 8'h40);
    chk("R10 fourth call target", fetch_addr, 12'h040);
    issue(8'hC0, 8'h00);
    chk("R10 pop newest", fetch_addr, 12'h032);
    issue(8'hC0, 8'h00);
    chk("R10 pop second", fetch_addr, 12'h022);
    issue(8'hC0, 8'h00);
    chk("R10 pop third", fetch_addr, 12'h012);
    issue(8'hC0, 8'h00);
    chk("R10 wrap repeats newest", fetch_addr, 12'h032);

    // R11 / R12: back-pressure on the return slot
    do_reset();
    issue(8'h52, 8'h00);
    ret_ready = 1'b0;
    issue(8'hC7, 8'h00);
    chk("R11 ret_valid set", ret_valid, 1'b1);
    chk("R11 ret_data", ret_data, 4'h7);
    chk("R9 return address", fetch_addr, 12'h002);
    drive(8'hA0, 8'h00, 8'h00, 4'b0001);
    #1;
    chk("R12 ready low while slot blocked", ins_ready, 1'b0);
    tick();
    chk("R12 pc held under stall", fetch_addr, 12'h002);
    chk("R11 data held", ret_data, 4'h7);
    chk("R11 valid held", ret_valid, 1'b1);
    // same cycle: drain the slot and take a new return
    ret_ready = 1'b1;
    drive(8'hC3, 8'h00, 8'h00, 4'b0001);
    #1;
    chk("R12 ready when draining", ins_ready, 1'b1);
    tick();
    ins_valid = 1'b0;
    chk("R11 slot reloaded", ret_valid, 1'b1);
    chk("R11 new data", ret_data, 4'h3);
    tick();
    chk("R11 slot drained", ret_valid, 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule